// File: doc/BRIEF.md
# Low-Power Standby Entry/Exit Sequencer

This block is a control state machine that takes a target device from normal operation into a standby mode in which its state is retained, and back again. On a standby request it holds the block resets low, gates every clock, switches off the DDR I/O supply regulator when hard DDR is present, and lowers the core supply. On a wake request it runs the opposite steps in reverse order. It raises the core supply first and waits out a separate ramp delay, then it restores the DDR I/O supply, enables the clocks, releases the block resets, and finally pulses a system reset.

Each step is followed by a wait that is counted in sequencer clock cycles. Build parameters set the general settle wait, the ramp wait after the supply rises, and the width of the system reset pulse. A request that arrives while a sequence is running is dropped. The block reports its current step and a busy flag. It gives a one-cycle done pulse when it returns to normal operation.

Top module: `pwr_standby_seq`

## Requirements
- R1: After reset the block is in normal operation. status is 0, busy and done are low, all block resets are high (released), all clock enables are high, the core select is low (nominal), sys_rst_n is high, and ddr_io_en is high when HAS_DDR=1 and low when HAS_DDR=0.
- R2: A standby request in normal operation lowers the block resets on the next clock edge. The clock enables fall SETTLE_CYC cycles later, ddr_io_en falls SETTLE_CYC cycles after that, and vcc_low_sel rises another SETTLE_CYC cycles later. status becomes 5 (standby) SETTLE_CYC cycles after the rise of vcc_low_sel.
- R3: The block resets stay low without a break from the step that asserts them, through standby, until the exit step that releases them.
- R4: A wake request in standby lowers vcc_low_sel on the next edge. Then, in order, ddr_io_en rises, the clock enables rise, and the block resets rise, with SETTLE_CYC cycles between the last two steps and between each of them and the next.
- R5: The step after the core supply is raised comes exactly RAMP_CYC cycles after vcc_low_sel falls.
- R6: With HAS_DDR=0 the DDR steps are skipped and ddr_io_en stays low. On entry, vcc_low_sel rises SETTLE_CYC cycles after the clocks are gated. On exit, the clock enables rise RAMP_CYC cycles after vcc_low_sel falls.
- R7: The clock enables are active high and all bits are always equal.
- R8: A wake request in normal operation, a standby request in standby, and any request while busy is high have no effect on the outputs, on the step timing or on the final state.
- R9: busy is high in every cycle of an entry or exit sequence and low in normal operation and in standby.
- R10: SETTLE_CYC cycles after the block resets are released, sys_rst_n is low for SYSRST_CYC cycles. The cycle in which it rises again, status returns to 0 and done is high for exactly one cycle.
- R11: status encodes the step: 0 normal, 1 resets, 2 clocks, 3 DDR off, 4 supply low, 5 standby, 6 supply up, 7 DDR on, 8 clocks on, 9 resets off, 10 system reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stby_req | input | 1 | Request to enter standby, sampled in normal operation |
| wake_req | input | 1 | Request to leave standby, sampled in standby |
| blk_rst_n | output | NUM_BLK | Active-low resets for the PLL and the hard blocks |
| clk_en | output | NUM_CLK | Active-high enables for the clock gates |
| ddr_io_en | output | 1 | Enable for the DDR I/O supply regulator |
| vcc_low_sel | output | 1 | Core supply select: 1 standby level, 0 nominal |
| sys_rst_n | output | 1 | Active-low system reset pulse at the end of exit |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse on return to normal operation |
| status | output | 4 | Current step code |

## Verification
The assertions assume that the settle, ramp and pulse parameters are at least 1 and that the requests are synchronous to clk. They also assume that outputs change only through the sequencer's own steps, so any edge on a reset, enable or supply select can be traced to one step. The stimulus drives requests as single-cycle pulses at the falling clock edge. It lets each sequence run to its end before it issues the next intended request. Extra requests are issued on purpose only inside busy windows or in the state that must ignore them.

// File: rtl/sby_pkg.sv
package sby_pkg;

  typedef enum logic [3:0] {
    ST_RUN     = 4'd0,
    ST_E_RST   = 4'd1,
    ST_E_CLK   = 4'd2,
    ST_E_DDR   = 4'd3,
    ST_E_VCC   = 4'd4,
    ST_STBY    = 4'd5,
    ST_X_VCC   = 4'd6,
    ST_X_DDR   = 4'd7,
    ST_X_CLK   = 4'd8,
    ST_X_RST   = 4'd9,
    ST_X_SYS   = 4'd10
  } sby_state_e;

  function automatic logic in_range(sby_state_e s, sby_state_e lo, sby_state_e hi);
    return (s >= lo) && (s <= hi);
  endfunction

endpackage

// File: rtl/sby_rst_sync.sv
module sby_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sby_wait_timer.sv
module sby_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R2: an idle timer never wraps around below zero
  assert_timer_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/sby_fsm.sv
module sby_fsm
  import sby_pkg::*;
#(
  parameter bit HAS_DDR    = 1'b1,
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 4,
  parameter int RAMP_CYC   = 8,
  parameter int SYSRST_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby_req,
  input  logic             wake_req,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output sby_state_e       state_q,
  output sby_state_e       state_d
);

  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] RAMP_LD   = CNT_W'(RAMP_CYC - 1);
  localparam logic [CNT_W-1:0] SYSRST_LD = CNT_W'(SYSRST_CYC - 1);
  localparam sby_state_e AFTER_E_CLK = HAS_DDR ? ST_E_DDR : ST_E_VCC;
  localparam sby_state_e AFTER_X_VCC = HAS_DDR ? ST_X_DDR : ST_X_CLK;

  function automatic logic [CNT_W-1:0] wait_for(sby_state_e s);
    case (s)
      ST_X_VCC: return RAMP_LD;
      ST_X_SYS: return SYSRST_LD;
      default:  return SETTLE_LD;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:   if (stby_req)    state_d = ST_E_RST;
      ST_E_RST: if (tmr_expired) state_d = ST_E_CLK;
      ST_E_CLK: if (tmr_expired) state_d = AFTER_E_CLK;
      ST_E_DDR: if (tmr_expired) state_d = ST_E_VCC;
      ST_E_VCC: if (tmr_expired) state_d = ST_STBY;
      ST_STBY:  if (wake_req)    state_d = ST_X_VCC;
      ST_X_VCC: if (tmr_expired) state_d = AFTER_X_VCC;
      ST_X_DDR: if (tmr_expired) state_d = ST_X_CLK;
      ST_X_CLK: if (tmr_expired) state_d = ST_X_RST;
      ST_X_RST: if (tmr_expired) state_d = ST_X_SYS;
      ST_X_SYS: if (tmr_expired) state_d = ST_RUN;
      default:                   state_d = ST_RUN;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign tmr_val  = wait_for(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  // checker counter: cycles spent in the supply-ramp step
  logic [CNT_W-1:0] ramp_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ramp_seen_q <= '0;
    else if (state_q == ST_X_VCC) ramp_seen_q <= ramp_seen_q + 1'b1;
    else                          ramp_seen_q <= '0;
  end

  // R5: the ramp step lasts the full ramp wait
  assert_ramp_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_X_VCC && state_d != ST_X_VCC) |-> (ramp_seen_q == RAMP_LD));

  // R8: standby is left only through the supply-up step
  assert_stby_exit_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_STBY && state_q != ST_STBY) |-> (state_q == ST_X_VCC));

  // R8: normal operation is left only through the reset step
  assert_run_exit_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_RUN && state_q != ST_RUN) |-> (state_q == ST_E_RST));

endmodule

// File: rtl/sby_out_regs.sv
module sby_out_regs
  import sby_pkg::*;
#(
  parameter bit HAS_DDR = 1'b1,
  parameter int NUM_BLK = 3,
  parameter int NUM_CLK = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  sby_state_e         state_q,
  input  sby_state_e         state_d,
  output logic [NUM_BLK-1:0] blk_rst_n,
  output logic [NUM_CLK-1:0] clk_en,
  output logic               ddr_io_en,
  output logic               vcc_low_sel,
  output logic               sys_rst_n,
  output logic               busy,
  output logic               done
);

  logic rst_hold_d, clk_gate_d, vlow_d, sys_d, busy_d, done_d, upd_en;

  assign upd_en     = (state_d != state_q) || done;
  assign rst_hold_d = in_range(state_d, ST_E_RST, ST_X_CLK);
  assign clk_gate_d = in_range(state_d, ST_E_CLK, ST_X_DDR);
  assign vlow_d     = in_range(state_d, ST_E_VCC, ST_STBY);
  assign sys_d      = (state_d == ST_X_SYS);
  assign busy_d     = (state_d != ST_RUN) && (state_d != ST_STBY);
  assign done_d     = (state_q == ST_X_SYS) && (state_d == ST_RUN);

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blk_rst_n[b] <= 1'b1;
      else if (upd_en) blk_rst_n[b] <= !rst_hold_d;
    end
  end

  for (genvar c = 0; c < NUM_CLK; c++) begin : g_clk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      clk_en[c] <= 1'b1;
      else if (upd_en) clk_en[c] <= !clk_gate_d;
    end
  end

  if (HAS_DDR) begin : g_ddr
    logic ddr_off_d;
    assign ddr_off_d = in_range(state_d, ST_E_DDR, ST_X_VCC);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ddr_io_en <= 1'b1;
      else if (upd_en) ddr_io_en <= !ddr_off_d;
    end
    // R2: the core supply drops only with the DDR supply already off
    assert_vcc_after_ddr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vcc_low_sel) |-> !ddr_io_en);
  end else begin : g_no_ddr
    assign ddr_io_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_low_sel <= 1'b0;
      sys_rst_n   <= 1'b1;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else if (upd_en) begin
      vcc_low_sel <= vlow_d;
      sys_rst_n   <= !sys_d;
      busy        <= busy_d;
      done        <= done_d;
    end
  end

  // R2: clocks are gated only while the block resets are held
  assert_gate_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en[0]) |-> (blk_rst_n == '0));
  // R3: the lowered supply always coincides with held resets and gated clocks
  assert_reset_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low_sel |-> (blk_rst_n == '0) && (clk_en == '0));
  // R4: clocks return only on the nominal supply
  assert_clk_on_nominal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en[0]) |-> !vcc_low_sel);
  // R4: resets release only once every clock runs
  assert_release_after_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_rst_n[0]) |-> (clk_en == '1));
  // R7: all clock enables move together
  assert_clk_en_uniform_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en == '0) || (clk_en == '1));
  // R10: done is a single-cycle pulse
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: the end of the system reset pulse is flagged by done
  assert_sysrst_end_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> done);

endmodule

// File: rtl/pwr_standby_seq.sv
module pwr_standby_seq
  import sby_pkg::*;
#(
  parameter bit HAS_DDR    = 1'b1,
  parameter int NUM_BLK    = 3,
  parameter int NUM_CLK    = 3,
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 4,
  parameter int RAMP_CYC   = 8,
  parameter int SYSRST_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stby_req,
  input  logic               wake_req,
  output logic [NUM_BLK-1:0] blk_rst_n,
  output logic [NUM_CLK-1:0] clk_en,
  output logic               ddr_io_en,
  output logic               vcc_low_sel,
  output logic               sys_rst_n,
  output logic               busy,
  output logic               done,
  output logic [3:0]         status
);

  logic             rst_sync_n;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  sby_state_e       state_q, state_d;

  sby_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sby_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sby_fsm #(
    .HAS_DDR    (HAS_DDR),
    .CNT_W      (CNT_W),
    .SETTLE_CYC (SETTLE_CYC),
    .RAMP_CYC   (RAMP_CYC),
    .SYSRST_CYC (SYSRST_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .stby_req    (stby_req),
    .wake_req    (wake_req),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .state_q     (state_q),
    .state_d     (state_d)
  );

  sby_out_regs #(
    .HAS_DDR (HAS_DDR),
    .NUM_BLK (NUM_BLK),
    .NUM_CLK (NUM_CLK)
  ) u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .state_q     (state_q),
    .state_d     (state_d),
    .blk_rst_n   (blk_rst_n),
    .clk_en      (clk_en),
    .ddr_io_en   (ddr_io_en),
    .vcc_low_sel (vcc_low_sel),
    .sys_rst_n   (sys_rst_n),
    .busy        (busy),
    .done        (done)
  );

  assign status = state_q;

  // R9: busy is low whenever the step code shows a resting state
  assert_busy_rest_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status == 4'd0 || status == 4'd5) |-> !busy);

endmodule

// File: tb/pwr_standby_seq_bench.sv
`timescale 1ns/1ps
module pwr_standby_seq_bench;

  localparam int NB = 3, NC = 3, S = 3, R = 10, P = 2;

  logic clk = 1'b0;
  logic rst_n, stby_req, wake_req;
  always #2.5 clk = ~clk;

  logic [NB-1:0] brst0, brst1;
  logic [NC-1:0] cen0, cen1;
  logic ddr0, ddr1, vl0, vl1, sys0, sys1, bsy0, bsy1, dn0, dn1;
  logic [3:0] st0, st1;

  pwr_standby_seq #(.HAS_DDR(1'b1), .NUM_BLK(NB), .NUM_CLK(NC), .SETTLE_CYC(S),
                    .RAMP_CYC(R), .SYSRST_CYC(P)) u_pwr_standby_seq (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .wake_req(wake_req),
    .blk_rst_n(brst0), .clk_en(cen0), .ddr_io_en(ddr0), .vcc_low_sel(vl0),
    .sys_rst_n(sys0), .busy(bsy0), .done(dn0), .status(st0));

  pwr_standby_seq #(.HAS_DDR(1'b0), .NUM_BLK(NB), .NUM_CLK(NC), .SETTLE_CYC(S),
                    .RAMP_CYC(R), .SYSRST_CYC(P)) u_pwr_standby_seq_noddr (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .wake_req(wake_req),
    .blk_rst_n(brst1), .clk_en(cen1), .ddr_io_en(ddr1), .vcc_low_sel(vl1),
    .sys_rst_n(sys1), .busy(bsy1), .done(dn1), .status(st1));

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // event stamps: 0 rst fall,1 rst rise,2 clk fall,3 clk rise,4 ddr fall,5 ddr rise,
  // 6 vlow rise,7 vlow fall,8 sys fall,9 sys rise,10 done rise
  int ev0 [11];
  int ev1 [11];
  int bc0, bc1, v3, mix7;
  logic [NB-1:0] pb0, pb1;
  logic [NC-1:0] pc0, pc1;
  logic pd0, pd1, pv0, pv1, ps0, ps1, pn0, pn1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pb0 != brst0) ev0[brst0[0] ? 1 : 0] = cyc;
      if (pc0 != cen0)  ev0[cen0[0] ? 3 : 2]  = cyc;
      if (pd0 != ddr0)  ev0[ddr0 ? 5 : 4]     = cyc;
      if (pv0 != vl0)   ev0[vl0 ? 6 : 7]      = cyc;
      if (ps0 != sys0)  ev0[sys0 ? 9 : 8]     = cyc;
      if (!pn0 && dn0)  ev0[10]               = cyc;
      if (pb1 != brst1) ev1[brst1[0] ? 1 : 0] = cyc;
      if (pc1 != cen1)  ev1[cen1[0] ? 3 : 2]  = cyc;
      if (pd1 != ddr1)  ev1[ddr1 ? 5 : 4]     = cyc;
      if (pv1 != vl1)   ev1[vl1 ? 6 : 7]      = cyc;
      if (ps1 != sys1)  ev1[sys1 ? 9 : 8]     = cyc;
      if (!pn1 && dn1)  ev1[10]               = cyc;
      if (bsy0) bc0++;
      if (bsy1) bc1++;
      // R3 monitor: resets must be low in every step between assertion and release
      if (st0 >= 4'd1 && st0 <= 4'd8 && brst0 != '0) v3++;
      if (st1 >= 4'd1 && st1 <= 4'd8 && brst1 != '0) v3++;
      // R7 monitor: enables never split
      if ((cen0 != '0 && cen0 != '1) || (cen1 != '0 && cen1 != '1)) mix7++;
    end
    pb0 = brst0; pc0 = cen0; pd0 = ddr0; pv0 = vl0; ps0 = sys0; pn0 = dn0;
    pb1 = brst1; pc1 = cen1; pd1 = ddr1; pv1 = vl1; ps1 = sys1; pn1 = dn1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm();
    for (int i = 0; i < 11; i++) begin ev0[i] = -1; ev1[i] = -1; end
    bc0 = 0; bc1 = 0;
  endtask

  task automatic pulse(input bit do_stby, input bit do_wake, output int t);
    @(negedge clk);
    stby_req = do_stby; wake_req = do_wake;
    t = cyc + 1;
    @(negedge clk);
    stby_req = 1'b0; wake_req = 1'b0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R1 status", st0, 0);        chk("R1 busy", bsy0, 0);
    chk("R1 done", dn0, 0);          chk("R1 blk_rst_n", brst0, 7);
    chk("R1 clk_en", cen0, 7);       chk("R1 ddr_io_en", ddr0, 1);
    chk("R1 vcc_low_sel", vl0, 0);   chk("R1 sys_rst_n", sys0, 1);
    chk("R1 ddr_io_en noddr", ddr1, 0);
  endtask

  task automatic t_run_wake_ignored();
    int t;
    arm();
    pulse(1'b0, 1'b1, t);
    wait_to(t + 8);
    chk("R8 wake in run status", st0, 0);
    chk("R8 wake in run busy cycles", bc0, 0);
    chk("R8 wake in run rst edge", ev0[0], -1);
    chk("R8 wake in run vlow edge", ev0[7], -1);
    chk("R8 wake in run clk_en", cen0, 7);
  endtask

  task automatic t_entry(input bit interfere);
    int t0, tx;
    arm();
    pulse(1'b1, 1'b0, t0);
    if (interfere) begin
      pulse(1'b0, 1'b1, tx);
      pulse(1'b1, 1'b1, tx);
    end
    wait_to(t0 + 4*S + 2);
    chk("R2 rst fall", ev0[0], t0);
    chk("R2 clk fall", ev0[2], t0 + S);
    chk("R2 ddr fall", ev0[4], t0 + 2*S);
    chk("R2 vlow rise", ev0[6], t0 + 3*S);
    chk("R11 status standby", st0, 5);
    chk("R9 entry busy cycles", bc0, 4*S);
    chk("R6 noddr clk fall", ev1[2], t0 + S);
    chk("R6 noddr vlow rise", ev1[6], t0 + 2*S);
    chk("R6 noddr ddr unchanged", ev1[4], -1);
    chk("R6 noddr standby status", st1, 5);
    chk("R9 noddr entry busy cycles", bc1, 3*S);
    if (interfere) chk("R8 entry with extra requests ends standby", st0, 5);
  endtask

  task automatic t_standby_hold();
    int t;
    arm();
    pulse(1'b1, 1'b0, t);
    wait_to(t + 10);
    chk("R8 stby in standby status", st0, 5);
    chk("R8 stby in standby busy", bc0, 0);
    chk("R3 resets held in standby", brst0, 0);
    chk("R7 clocks gated in standby", cen0, 0);
    chk("R2 supply low in standby", vl0, 1);
    chk("R8 no edge in standby", ev0[7], -1);
  endtask

  task automatic t_exit(input bit interfere);
    int t1, tx, tend;
    arm();
    pulse(1'b0, 1'b1, t1);
    if (interfere) begin
      pulse(1'b1, 1'b0, tx);
      pulse(1'b1, 1'b1, tx);
    end
    tend = t1 + R + 3*S + P;
    wait_to(tend + 3);
    chk("R4 vlow fall", ev0[7], t1);
    chk("R5 ddr rise after ramp", ev0[5], t1 + R);
    chk("R4 clk rise", ev0[3], t1 + R + S);
    chk("R4 rst rise", ev0[1], t1 + R + 2*S);
    chk("R10 sys fall", ev0[8], t1 + R + 3*S);
    chk("R10 sys rise", ev0[9], tend);
    chk("R10 done rise", ev0[10], tend);
    chk("R10 done low after pulse", dn0, 0);
    chk("R11 status back to run", st0, 0);
    chk("R9 exit busy cycles", bc0, R + 3*S + P);
    chk("R6 noddr clk rise after ramp", ev1[3], t1 + R);
    chk("R6 noddr sys rise", ev1[9], t1 + R + 2*S + P);
    chk("R6 noddr ddr unchanged", ev1[5], -1);
    chk("R3 resets never released early", v3, 0);
    chk("R7 enables uniform", mix7, 0);
    if (interfere) chk("R8 exit with extra requests ends run", st1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stby_req = 1'b0; wake_req = 1'b0;
    v3 = 0; mix7 = 0;
    arm();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_run_wake_ignored();
    t_entry(1'b0);
    t_standby_hold();
    t_exit(1'b0);
    t_entry(1'b1);
    t_exit(1'b1);
    t_run_wake_ignored();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule